// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a write-only serial slave. It takes 16-bit configuration words on a three-wire link made of an active-low select, a serial clock and a data line, and turns them into parallel control outputs. The outputs are a gain code, power-mode bits, an active-low reset-control bit, polarity bits, frequency-select fields and a few mode flags.

The block runs on a fast system clock and oversamples the serial pins through two-flop synchronisers. Each frame carries a three-bit slot address in its top bits. A frame changes a register only when select returns high after exactly 16 serial clock rising edges. Frames that are short or long leave every register unchanged, and so do frames addressed to the reserved slots.

The system clock must run at least eight times faster than the serial clock. The serial clock may run at up to 5 MHz.

Top module: `sercfg_bank`

## Requirements
- R1: After system reset every output is 0. This includes `core_run`, so the controlled circuits stay held in reset until slot 2 is written.
- R2: The data line is sampled on each serial clock rising edge while select is low. Bit 0 of the frame arrives first and bit 15 arrives last. Frame bits [15:13] are the slot address and bits [12:0] are the payload.
- R3: A complete frame changes no output before select rises. The new value shows up on the outputs within 6 system clocks of that rising edge.
- R4: A frame that ends with fewer than 16 serial clock rising edges changes no register.
- R5: A frame with more than 16 serial clock rising edges changes no register.
- R6: A frame addressed to slots 4 to 7 changes no register. Only slots 0 to 3 are writable.
- R7: Slot 0 holds the gain code in payload bits [7:0] and `in_mode` in bit 8.
- R8: Slot 1 holds the following fields, where 0 means normal operation for both power bits:
  - `sleep_en` in bit 0
  - `stby_en` in bit 1
  - `line_inv` in bit 2
  - `mid_inv` in bit 3
  - `amp_fsel` in bits [5:4]
  - `sw_fsel` in bits [9:6]
- R9: Slot 2 holds the following fields:
  - `clamp_lvl` in bits [4:0]
  - `low_pwr` in bit 5
  - `pulse_inv` in bit 6
  - `ob_inv` in bit 7
  - `core_run` in bit 8, where 0 means reset mode and 1 means normal operation

  Slot 3 holds `bias_off` in bit 0 and `avg4` in bit 1.
- R10: Serial clock edges that occur while select is high are ignored. They neither add to the next frame nor change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_din | input | 1 | Serial data, LSB first |
| gain_code | output | 8 | Gain code (slot 0) |
| in_mode | output | 1 | Input mode select (slot 0) |
| sleep_en | output | 1 | Sleep request (slot 1) |
| stby_en | output | 1 | Standby request (slot 1) |
| line_inv | output | 1 | Line output inversion (slot 1) |
| mid_inv | output | 1 | Mid output inversion (slot 1) |
| amp_fsel | output | 2 | Amplifier bandwidth select (slot 1) |
| sw_fsel | output | 4 | Switch bandwidth select (slot 1) |
| clamp_lvl | output | 5 | Clamp level (slot 2) |
| low_pwr | output | 1 | Low-power mode (slot 2) |
| pulse_inv | output | 1 | Sampling pulse inversion (slot 2) |
| ob_inv | output | 1 | Black-level pulse inversion (slot 2) |
| core_run | output | 1 | 0 holds the controlled circuits in reset (slot 2) |
| bias_off | output | 1 | Bias disable (slot 3) |
| avg4 | output | 1 | Four-line averaging (slot 3) |

## Verification
The hardest case to reach is a frame whose length is wrong by exactly one clock. A count of 15 or 17 leaves a shift register that looks plausible, and the commit must still be refused. A 17-clock frame also leaves a valid-looking address in the top bits.

The stimulus builds each frame from a random slot address and a random payload. The clock count is usually 16, but 15, 17, 12 or 20 are picked often enough that both neighbours of 16 occur many times. The bench inserts serial clock pulses while select is high between frames, and it checks the outputs between the last clock and the select rising edge.

// File: rtl/sercfg_bank.sv
module sercfg_bank #(
  parameter int FRAME_BITS  = 16,
  parameter int ADDR_W      = 3,
  parameter int USER_REGS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_sel_n,
  input  logic       ser_din,
  output logic [7:0] gain_code,
  output logic       in_mode,
  output logic       sleep_en,
  output logic       stby_en,
  output logic       line_inv,
  output logic       mid_inv,
  output logic [1:0] amp_fsel,
  output logic [3:0] sw_fsel,
  output logic [4:0] clamp_lvl,
  output logic       low_pwr,
  output logic       pulse_inv,
  output logic       ob_inv,
  output logic       core_run,
  output logic       bias_off,
  output logic       avg4
);

  localparam int PL_W = FRAME_BITS - ADDR_W;
  localparam int CW   = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic [SYNC_STAGES:0] sck_p, sel_p, din_p;
  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic [USER_REGS-1:0][PL_W-1:0] cfg_q;

  wire sck_rise = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  wire sel_lo   = ~sel_p[SYNC_STAGES-1];
  wire sel_rise = sel_p[SYNC_STAGES-1] & ~sel_p[SYNC_STAGES];
  wire din_s    = din_p[SYNC_STAGES-1];

  wire [ADDR_W-1:0] addr    = shreg[FRAME_BITS-1 -: ADDR_W];
  wire [PL_W-1:0]   payload = shreg[PL_W-1:0];
  wire frame_ok = sel_rise && (bit_cnt == CNT_FULL);
  wire slot_ok  = int'(addr) < USER_REGS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '1;
      din_p <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], ser_clk};
      sel_p <= {sel_p[SYNC_STAGES-1:0], ser_sel_n};
      din_p <= {din_p[SYNC_STAGES-1:0], ser_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!sel_lo) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {din_s, shreg[FRAME_BITS-1:1]};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (frame_ok && slot_ok) begin
      for (int i = 0; i < USER_REGS; i++)
        if (int'(addr) == i) cfg_q[i] <= payload;
    end
  end

  assign gain_code = cfg_q[0][7:0];
  assign in_mode   = cfg_q[0][8];
  assign sleep_en  = cfg_q[1][0];
  assign stby_en   = cfg_q[1][1];
  assign line_inv  = cfg_q[1][2];
  assign mid_inv   = cfg_q[1][3];
  assign amp_fsel  = cfg_q[1][5:4];
  assign sw_fsel   = cfg_q[1][9:6];
  assign clamp_lvl = cfg_q[2][4:0];
  assign low_pwr   = cfg_q[2][5];
  assign pulse_inv = cfg_q[2][6];
  assign ob_inv    = cfg_q[2][7];
  assign core_run  = cfg_q[2][8];
  assign bias_off  = cfg_q[3][0];
  assign avg4      = cfg_q[3][1];

  // R3
  commit_at_sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rise |=> $stable(cfg_q));

  // R4
  wrong_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && bit_cnt != CNT_FULL) |=> $stable(cfg_q));

  // R6
  reserved_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !slot_ok) |=> $stable(cfg_q));

  // R10
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lo |=> (bit_cnt == '0));

  // R2
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo && sck_rise && bit_cnt != CNT_MAX) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

// File: tb/tb_sercfg_bank.sv
module tb_sercfg_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, din = 1'b0;
  logic [7:0] gain_code; logic in_mode, sleep_en, stby_en, line_inv, mid_inv;
  logic [1:0] amp_fsel; logic [3:0] sw_fsel; logic [4:0] clamp_lvl;
  logic low_pwr, pulse_inv, ob_inv, core_run, bias_off, avg4;

  int n_cmp = 0, n_bad = 0;
  logic [3:0][12:0] m;

  always #2 clk = ~clk;

  sercfg_bank dut (.clk, .rst_n, .ser_clk(sck), .ser_sel_n(sel_n), .ser_din(din),
    .gain_code, .in_mode, .sleep_en, .stby_en, .line_inv, .mid_inv, .amp_fsel,
    .sw_fsel, .clamp_lvl, .low_pwr, .pulse_inv, .ob_inv, .core_run, .bias_off, .avg4);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_r3(input logic [12:0] r);
    return {11'b0, r[1:0]};
  endfunction

  task automatic check_all(input string tag);
    chk({tag, "/R7"}, {23'b0, in_mode, gain_code}, {23'b0, m[0][8:0]});
    chk({tag, "/R8"}, {22'b0, sw_fsel, amp_fsel, mid_inv, line_inv, stby_en, sleep_en},
        {22'b0, m[1][9:0]});
    chk({tag, "/R9"}, {23'b0, core_run, ob_inv, pulse_inv, low_pwr, clamp_lvl},
        {23'b0, m[2][8:0]});
    chk({tag, "/R9"}, {30'b0, avg4, bias_off}, {19'b0, exp_r3(m[3])});
  endtask

  task automatic send(input logic [15:0] w, input int nclk, input string tag, input bit mid);
    sel_n = 1'b0; #100;
    for (int i = 0; i < nclk; i++) begin
      din = (i < 16) ? w[i] : 1'b0;
      #100 sck = 1'b1;
      #100 sck = 1'b0;
    end
    #100;
    if (mid) check_all({tag, "-mid/R3"});
    sel_n = 1'b1;
    #200;
    if (nclk == 16 && w[15:13] < 3'd4) m[w[15:13]] = w[12:0];
    check_all(tag);
  endtask

  task automatic idle_glitch(input int n);
    for (int i = 0; i < n; i++) begin
      din = 1'b1;
      #100 sck = 1'b1;
      #100 sck = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    m = '0;
    #40 rst_n = 1'b1;
    #40 check_all("R1");
    send({3'd0, 13'h0A5}, 16, "R2", 1'b1);
    send({3'd2, 13'h100}, 16, "R9", 1'b0);
    send({3'd1, 13'h003}, 16, "R8", 1'b0);
    send({3'd3, 13'h003}, 16, "R9", 1'b0);
    send({3'd0, 13'h1FF}, 15, "R4", 1'b0);
    send({3'd0, 13'h1FF}, 17, "R5", 1'b0);
    send({3'd5, 13'h1FF}, 16, "R6", 1'b0);
    send({3'd7, 13'h1FF}, 16, "R6", 1'b0);
    idle_glitch(5);
    send({3'd1, 13'h3C0}, 16, "R10", 1'b0);
    idle_glitch(20);
    send({3'd2, 13'h01F}, 16, "R10", 1'b0);
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w;
      int len, pick;
      w = 16'($urandom);
      pick = int'($urandom % 10);
      case (pick)
        0: len = 15;
        1: len = 17;
        2: len = 12;
        3: len = 20;
        default: len = 16;
      endcase
      if ($urandom % 4 == 0) idle_glitch(int'($urandom % 3) + 1);
      send(w, len, (len == 16) ? ((w[15:13] > 3'd3) ? "R6" : "R2") : "R4", k[2]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule